// File: doc/BRIEF.md
# Reference Clock Failover Monitor

This block picks the reference that feeds a base-clock PLL. Two 100 MHz candidates exist: a clock delivered over the backplane and an oscillator on the board. The block runs in the always-available oscillator domain. It watches a toggle signal that flips once per backplane clock edge group, and it watches the PLL lock indication. It drives two outputs: a reference-select line and a PLL reset line. After reset it prefers the backplane clock. If that clock shows no activity, or if lock is lost or never reached while it is in use, the block moves to the oscillator and stays there.

Each change of reference is followed by the same relock sequence. The block holds the PLL in reset for a fixed number of cycles, releases it, and then waits a bounded time for lock. A status flag is set when lock drops after it has been reached. That flag stays set until the next full reset, so software can tell that the clocks it sees are no longer the ones it configured and can reload the design. The flag is meant to be read in the 40 MHz domain that the PLL produces. That crossing lies outside this block.

Top module: `refclk_failover`

## Requirements
- R1: While reset is asserted, `ref_sel` is 0 (backplane), `pll_rst` is 1, `unlocked_sticky` is 0 and `bp_present` is 0.
- R2: When the backplane toggle is active during the probe phase, the block keeps `ref_sel` at 0, releases `pll_rst`, and stays on the backplane once the PLL locks.
- R3: When no backplane activity is seen during the probe phase, `ref_sel` is still 0 two cycles after reset release and becomes 1 (oscillator) exactly PROBE_CYCLES cycles after reset release.
- R4: Every relock after a lock loss or a timeout holds `pll_rst` high for exactly RST_CYCLES consecutive cycles.
- R5: Loss of lock while running on the backplane sets `ref_sel` to 1 and sets `unlocked_sticky`.
- R6: `unlocked_sticky` stays set through any later relock and clears only on reset.
- R7: Once `ref_sel` is 1 it does not return to 0 before the next reset, even when backplane activity resumes.
- R8: If lock does not arrive within LOCK_TIMEOUT cycles after `pll_rst` falls, `pll_rst` rises again after exactly LOCK_TIMEOUT low cycles and `ref_sel` becomes 1. A lock that was never reached does not set `unlocked_sticky`.
- R9: If backplane activity stops while the block is waiting for lock on the backplane, it fails over to the oscillator before the lock timeout expires.
- R10: `bp_present` stays high continuously when the toggle changes at least once every ACT_WINDOW cycles, and it drops at some point when the toggle's intervals are longer than ACT_WINDOW.
- R11: `ref_sel` changes only in a cycle in which `pll_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low synchronous full reset |
| bp_toggle | input | 1 | Asynchronous activity toggle from the backplane clock |
| pll_locked | input | 1 | Asynchronous PLL lock indication |
| ref_sel | output | 1 | PLL reference: 0 backplane, 1 oscillator |
| pll_rst | output | 1 | PLL reset, active high |
| bp_present | output | 1 | Backplane activity seen within the window |
| unlocked_sticky | output | 1 | Lock was lost after having been reached since reset |

## Verification
A sequencer stuck in the wrong state shows at the ports as a `pll_rst` pulse or gap of the wrong length. The bench measures those lengths to the exact cycle after every relock, so such an error appears on the first relock following it. A wrong source register shows as a switch back to the backplane or a failover that never happens, and this is visible within one probe or timeout window. A miscounting activity window is exposed by the sweep of toggle intervals on both sides of ACT_WINDOW.

// File: rtl/refclk_fo_pkg.sv
package refclk_fo_pkg;
   typedef enum logic [1:0] {
      ST_PROBE = 2'd0,
      ST_HOLD  = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RUN   = 2'd3
   } fo_state_e;

   typedef enum logic {
      SRC_BACKPLANE = 1'b0,
      SRC_OSC       = 1'b1
   } ref_src_e;
endpackage

// File: rtl/fo_sync.sv
module fo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fo_activity.sv
module fo_activity #(
   parameter int SYNC_STAGES = 2,
   parameter int WINDOW      = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic toggle_async,
   output logic present
);
   localparam int CW = $clog2(WINDOW + 1);
   localparam logic [CW-1:0] WIN_V = CW'(WINDOW);

   logic          tog_s;
   logic          tog_d;
   logic          edge_seen;
   logic [CW-1:0] since_edge;

   fo_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   (toggle_async),
      .q   (tog_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) tog_d <= 1'b0;
      else        tog_d <= tog_s;
   end

   assign edge_seen = tog_s ^ tog_d;

   // Counter saturates at WINDOW, which means "no activity".
   always_ff @(posedge clk) begin
      if (!rst_n)                since_edge <= WIN_V;
      else if (edge_seen)        since_edge <= '0;
      else if (since_edge != WIN_V) since_edge <= since_edge + 1'b1;
   end

   assign present = (since_edge != WIN_V);

   // R10: an observed edge makes the presence indication true next cycle
   a_r10_edge_marks_present: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen |=> present);
endmodule

// File: rtl/fo_sequencer.sv
module fo_sequencer
   import refclk_fo_pkg::*;
#(
   parameter int PROBE_CYCLES = 32,
   parameter int RST_CYCLES   = 8,
   parameter int LOCK_TIMEOUT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bp_active,
   input  logic locked,
   output logic ref_sel,
   output logic pll_rst,
   output logic unlocked_sticky
);
   localparam int CNT_MAX0 = (PROBE_CYCLES > RST_CYCLES) ? PROBE_CYCLES : RST_CYCLES;
   localparam int CNT_MAX  = (CNT_MAX0 > LOCK_TIMEOUT) ? CNT_MAX0 : LOCK_TIMEOUT;
   localparam int CW       = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] PROBE_LAST = CW'(PROBE_CYCLES - 1);
   localparam logic [CW-1:0] HOLD_LAST  = CW'(RST_CYCLES - 1);
   localparam logic [CW-1:0] WAIT_LAST  = CW'(LOCK_TIMEOUT - 1);

   fo_state_e     state;
   ref_src_e      src;
   logic [CW-1:0] cnt;
   logic          sticky;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_PROBE;
         src    <= SRC_BACKPLANE;
         cnt    <= '0;
         sticky <= 1'b0;
      end else begin
         case (state)
            ST_PROBE: begin
               if (bp_active) begin
                  state <= ST_HOLD;
                  cnt   <= '0;
               end else if (cnt == PROBE_LAST) begin
                  src   <= SRC_OSC;
                  state <= ST_HOLD;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_HOLD: begin
               if (cnt == HOLD_LAST) begin
                  state <= ST_WAIT;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_WAIT: begin
               if (locked) begin
                  state <= ST_RUN;
                  cnt   <= '0;
               end else if ((src == SRC_BACKPLANE && !bp_active) || cnt == WAIT_LAST) begin
                  src   <= SRC_OSC;
                  state <= ST_HOLD;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_RUN: begin
               if (!locked) begin
                  sticky <= 1'b1;
                  src    <= SRC_OSC;
                  state  <= ST_HOLD;
                  cnt    <= '0;
               end
            end
            default: begin
               state <= ST_PROBE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign ref_sel         = src;
   assign pll_rst         = (state == ST_PROBE) || (state == ST_HOLD);
   assign unlocked_sticky = sticky;

   // R7: the oscillator choice is one-way
   a_r7_no_switchback: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_sel == 1'b1) |=> (ref_sel == 1'b1));
   // R6: sticky flag never clears without reset
   a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked_sticky |=> unlocked_sticky);
   // R5: the flag rises together with a failover into the reset hold
   a_r5_sticky_with_failover: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked_sticky) |-> (ref_sel && pll_rst));
   // R11: reference changes only while the PLL is held in reset
   a_r11_switch_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ref_sel) |-> pll_rst);
   // R8: the lock wait never outlasts its timeout
   a_r8_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> (cnt <= WAIT_LAST));
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover #(
   parameter int SYNC_STAGES  = 2,
   parameter int ACT_WINDOW   = 16,
   parameter int RST_CYCLES   = 8,
   parameter int LOCK_TIMEOUT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bp_toggle,
   input  logic pll_locked,
   output logic ref_sel,
   output logic pll_rst,
   output logic bp_present,
   output logic unlocked_sticky
);
   localparam int PROBE_CYCLES = 2 * ACT_WINDOW;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ACT_WINDOW < 2) begin : g_bad_win
         $error("ACT_WINDOW must be at least 2");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
      if (LOCK_TIMEOUT <= ACT_WINDOW) begin : g_bad_to
         $error("LOCK_TIMEOUT must exceed ACT_WINDOW");
      end
   endgenerate

   logic lock_s;
   logic active;

   fo_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pll_locked),
      .q     (lock_s)
   );

   fo_activity #(
      .SYNC_STAGES (SYNC_STAGES),
      .WINDOW      (ACT_WINDOW)
   ) u_act (
      .clk          (clk),
      .rst_n        (rst_n),
      .toggle_async (bp_toggle),
      .present      (active)
   );

   fo_sequencer #(
      .PROBE_CYCLES (PROBE_CYCLES),
      .RST_CYCLES   (RST_CYCLES),
      .LOCK_TIMEOUT (LOCK_TIMEOUT)
   ) u_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .bp_active       (active),
      .locked          (lock_s),
      .ref_sel         (ref_sel),
      .pll_rst         (pll_rst),
      .unlocked_sticky (unlocked_sticky)
   );

   assign bp_present = active;
endmodule

// File: tb/sim_refclk_failover.sv
`timescale 1ns/1ps
module sim_refclk_failover;
   localparam int SYNC = 2;
   localparam int WIN  = 8;
   localparam int RSTC = 3;
   localparam int TOUT = 40;
   localparam int PROBE = 2 * WIN;
   localparam int LOCK_DLY = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bp_toggle = 1'b0;
   logic pll_locked = 1'b0;
   logic ref_sel, pll_rst, bp_present, unlocked_sticky;

   always #2.5 clk = ~clk;

   refclk_failover #(
      .SYNC_STAGES (SYNC), .ACT_WINDOW (WIN), .RST_CYCLES (RSTC), .LOCK_TIMEOUT (TOUT)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .bp_toggle (bp_toggle), .pll_locked (pll_locked),
      .ref_sel (ref_sel), .pll_rst (pll_rst), .bp_present (bp_present),
      .unlocked_sticky (unlocked_sticky)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // Stimulus controls
   bit bp_run    = 1'b1;
   int bp_half   = 2;
   bit bp_refuse = 1'b0;
   bit osc_ok    = 1'b1;
   bit kill_lock = 1'b0;

   // Backplane activity toggle
   int tcnt = 0;
   always @(negedge clk) begin
      if (bp_run) begin
         if (tcnt >= bp_half - 1) begin
            bp_toggle <= ~bp_toggle;
            tcnt = 0;
         end else tcnt++;
      end
   end

   // PLL model
   int lcnt = 0;
   always @(posedge clk) begin
      bit ref_ok;
      ref_ok = ref_sel ? osc_ok : (bp_run && !bp_refuse);
      if (pll_rst || !ref_ok || kill_lock || !rst_n) begin
         lcnt = 0;
         pll_locked <= 1'b0;
      end else begin
         if (lcnt < 1000) lcnt++;
         pll_locked <= (lcnt >= LOCK_DLY);
      end
   end

   // Pulse-width monitor on pll_rst
   int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0, hi_pulses = 0;
   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         hi_run = 0; lo_run = 0; last_hi = 0; last_lo = 0; hi_pulses = 0;
      end else if (pll_rst) begin
         hi_run++;
         if (lo_run != 0) begin last_lo = lo_run; lo_run = 0; end
      end else begin
         lo_run++;
         if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; hi_pulses++; end
      end
   end

   // Watchdog
   always @(negedge clk) begin
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles, expected < 150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Wait until the PLL model reports lock and the block has released reset
   task automatic wait_lock(input string req, input int max);
      int n = 0;
      while (!(pll_locked && !pll_rst) && n < max) begin
         @(negedge clk); n++;
      end
      chk(n < max, req, n, max);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cycles(4);
      rst_n = 1'b1;
   endtask

   initial begin
      // R1: outputs held in reset
      rst_n = 1'b0;
      cycles(4);
      chk(ref_sel == 1'b0, "R1 ref_sel", ref_sel, 0);
      chk(pll_rst == 1'b1, "R1 pll_rst", pll_rst, 1);
      chk(unlocked_sticky == 1'b0, "R1 sticky", unlocked_sticky, 0);
      chk(bp_present == 1'b0, "R1 bp_present", bp_present, 0);

      // R2: backplane active, stays on backplane
      rst_n = 1'b1;
      wait_lock("R2 lock on backplane", 200);
      cycles(20);
      chk(ref_sel == 1'b0, "R2 ref_sel", ref_sel, 0);
      chk(unlocked_sticky == 1'b0, "R2 sticky", unlocked_sticky, 0);

      // R5: lock loss while on backplane
      kill_lock = 1'b1;
      cycles(5);
      kill_lock = 1'b0;
      cycles(2);
      chk(ref_sel == 1'b1, "R5 failover ref_sel", ref_sel, 1);
      chk(unlocked_sticky == 1'b1, "R5 sticky set", unlocked_sticky, 1);
      wait_lock("R5 relock on oscillator", 200);
      cycles(2);
      chk(last_hi == RSTC, "R4 reset width after lock loss", last_hi, RSTC);
      // R6: survives relock
      chk(unlocked_sticky == 1'b1, "R6 sticky after relock", unlocked_sticky, 1);

      // R7: backplane still running, no return
      begin
         int back = 0;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (ref_sel == 1'b0) back++;
         end
         chk(back == 0, "R7 no switchback", back, 0);
      end
      // R4/R7: lock loss on oscillator relocks on oscillator
      kill_lock = 1'b1;
      cycles(3);
      kill_lock = 1'b0;
      wait_lock("R4 relock second", 200);
      cycles(2);
      chk(last_hi == RSTC, "R4 reset width second", last_hi, RSTC);
      chk(ref_sel == 1'b1, "R7 stays oscillator", ref_sel, 1);

      // R6: reset clears the flag
      rst_n = 1'b0;
      cycles(3);
      chk(unlocked_sticky == 1'b0, "R6 cleared by reset", unlocked_sticky, 0);

      // R3: no backplane activity
      bp_run = 1'b0;
      cycles(2 * WIN);
      rst_n = 1'b1;
      cycles(2);
      chk(ref_sel == 1'b0, "R3 default backplane", ref_sel, 0);
      cycles(PROBE - 2);
      chk(ref_sel == 1'b1, "R3 oscillator after probe", ref_sel, 1);
      wait_lock("R3 lock on oscillator", 200);
      chk(unlocked_sticky == 1'b0, "R3 sticky clear", unlocked_sticky, 0);

      // R8: PLL refuses the backplane, timeout forces oscillator
      bp_run = 1'b1;
      bp_half = 2;
      bp_refuse = 1'b1;
      do_reset();
      begin
         int n = 0;
         while (ref_sel == 1'b0 && n < 500) begin @(negedge clk); n++; end
         cycles(2);
      end
      chk(ref_sel == 1'b1, "R8 timeout failover", ref_sel, 1);
      chk(last_lo == TOUT, "R8 wait length", last_lo, TOUT);
      wait_lock("R8 lock after timeout", 200);
      chk(unlocked_sticky == 1'b0, "R8 no sticky for never-locked", unlocked_sticky, 0);

      // R8/R4: oscillator never locks, retry loop
      bp_refuse = 1'b0;
      bp_run = 1'b0;
      osc_ok = 1'b0;
      do_reset();
      cycles(PROBE + 4 * (TOUT + RSTC));
      chk(last_lo == TOUT, "R8 retry wait length", last_lo, TOUT);
      chk(last_hi == RSTC, "R4 retry reset width", last_hi, RSTC);
      chk(hi_pulses >= 3, "R8 retries repeat", hi_pulses, 3);
      chk(ref_sel == 1'b1, "R8 retry on oscillator", ref_sel, 1);
      osc_ok = 1'b1;

      // R9: backplane stops while waiting for lock
      bp_run = 1'b1;
      bp_refuse = 1'b1;
      do_reset();
      begin
         int n = 0;
         while (pll_rst && n < 200) begin @(negedge clk); n++; end
      end
      cycles(3);
      bp_run = 1'b0;
      begin
         int n = 0;
         while (ref_sel == 1'b0 && n < 200) begin @(negedge clk); n++; end
         cycles(2);
      end
      chk(ref_sel == 1'b1, "R9 failover on lost activity", ref_sel, 1);
      chk(last_lo < TOUT, "R9 before timeout", last_lo, TOUT - 1);
      bp_refuse = 1'b0;

      // R10: sweep toggle intervals across the window
      bp_run = 1'b1;
      for (int p = 1; p <= WIN + 3; p++) begin
         int absent = 0;
         bp_half = p;
         cycles(3 * WIN + 2 * p);
         for (int i = 0; i < 4 * (WIN + 3); i++) begin
            @(negedge clk);
            if (!bp_present) absent++;
         end
         if (p <= WIN) chk(absent == 0, "R10 present steady", absent, 0);
         else          chk(absent > 0, "R10 gaps seen", absent, 1);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule